// File: doc/BRIEF.md
# Dual-Half Monochrome LCD Scan Controller

This block keeps refreshing a 1-bit-per-pixel LCD glass that holds no image memory of its own. The glass is split into an upper and a lower half. Both halves load in parallel over one 8-bit bus, which carries 4 pixels for each half on every shift. The block generates three things: the shift clock, the line latch pulse, and the frame-start marker. It also reads the pixels it needs from an external frame store, using a one-cycle synchronous read port addressed by line and column. The default geometry is 640x480: 160 shifts per line and 242 line periods per frame. The last two line periods are dummy lines that the glass does not show.

Shift-clock timing comes from an elapsed-time accumulator. It adds the system clock period in nanoseconds on every cycle and compares the total against a programmable minimum shift period. A high phase ends once the time would pass half that minimum. After reset the block sends one startup shift with the latch high and the bus at zero, then moves into line 0, column 0.

Top module: `mono_lcd_scan`

## Requirements
- R1: A synchronous active-high reset drives every output low: shift clock, latch, frame start, both pixel nibbles and the fetch strobe.
- R2: On the first clock after reset the shift clock and the latch rise together. This is the startup shift: the bus is zero, the frame marker is low, and no fetch precedes it.
- R3: The shift clock stays high for H cycles, where H is the smallest n with n*CLK_NS > SCK_MIN_NS/2. Rising edges are P cycles apart, where P is the larger of H+3 and the smallest n with n*CLK_NS > SCK_MIN_NS.
- R4: The pixel nibbles change only in the cycle the shift clock rises, and they hold for the whole high phase.
- R5: Before each shift of a visible line, the fetch strobe is high for exactly one cycle, two cycles before the rise. During that cycle it carries that shift's line and column. The word returned in the next cycle goes onto the bus at the rise: bits 7:4 to the upper half, bits 3:0 to the lower half.
- R6: The latch rises together with the shift clock on the last column of a line, or on the startup shift. It falls one cycle before the next rise, so it is always low in the cycle just before any shift-clock rise.
- R7: The frame marker is set at the column-0 shift of line 0 and cleared at the column-0 shift of line 1. It changes at no other time.
- R8: In line periods at or beyond SHOWN (the dummy lines) no fetch is issued, and both nibbles are zero.
- R9: Columns wrap to 0 after COLS-1. Lines wrap to 0 after LINES-1, and the next frame then starts with the frame marker raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk | output | 1 | Pixel shift clock; the glass captures data on its falling edge |
| line_latch | output | 1 | Line latch pulse |
| frame_start | output | 1 | Frame-start marker, high for the whole of line 0 |
| upper_px | output | 4 | Four pixels for the upper half |
| lower_px | output | 4 | Four pixels for the lower half |
| fetch_en | output | 1 | Frame-store read strobe |
| fetch_line | output | $clog2(LINES) | Line index of the read |
| fetch_col | output | $clog2(COLS) | Column (shift) index of the read |
| fetch_word | input | 8 | Read data, valid in the cycle after the strobe |

## Verification
The hardest situation to reach is the boundary between frames. There the last dummy line hands over to line 0: the frame marker must rise again, fetching must resume at column 0, and the latch from the final dummy shift must already be low. The bench shrinks the geometry to 8 columns and 6 line periods, so that several frame wraps fit into one run. It also fires resets at random points, which replays the startup shift from the middle of lines and dummy lines. Each shift is checked against a model that derives the expected line, column, word and pulse levels from a shift index counted since the last reset.

// File: rtl/mono_lcd_scan.sv
module mono_lcd_scan #(
  parameter int CLK_NS     = 31,
  parameter int SCK_MIN_NS = 166,
  parameter int COLS       = 160,
  parameter int LINES      = 242,
  parameter int SHOWN      = 240
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic                     shift_clk,
  output logic                     line_latch,
  output logic                     frame_start,
  output logic [3:0]               upper_px,
  output logic [3:0]               lower_px,
  output logic                     fetch_en,
  output logic [$clog2(LINES)-1:0] fetch_line,
  output logic [$clog2(COLS)-1:0]  fetch_col,
  input  logic [7:0]               fetch_word
);
  localparam int CW = $clog2(COLS);
  localparam int LW = $clog2(LINES);
  localparam int TW = $clog2(SCK_MIN_NS + 4 * CLK_NS + 1);
  localparam logic [TW+1:0] STEP  = (TW+2)'(CLK_NS);
  localparam logic [TW+1:0] HALF  = (TW+2)'(SCK_MIN_NS / 2);
  localparam logic [TW+1:0] FULL  = (TW+2)'(SCK_MIN_NS);

  typedef enum logic [2:0] {S_BOOT, S_HI, S_LO, S_REQ, S_WAIT} st_t;

  st_t st;
  logic [TW-1:0] el;
  logic [CW-1:0] col;
  logic [LW-1:0] line;

  wire [TW+1:0] el_1 = {2'b00, el} + STEP;
  wire [TW+1:0] el_3 = {2'b00, el} + 3 * STEP;
  wire last_col  = col == CW'(COLS - 1);
  wire last_line = line == LW'(LINES - 1);
  wire vis       = line < LW'(SHOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_BOOT;
      el <= '0;
      col <= '0;
      line <= '0;
      shift_clk <= 1'b0;
      line_latch <= 1'b0;
      frame_start <= 1'b0;
      upper_px <= '0;
      lower_px <= '0;
      fetch_en <= 1'b0;
      fetch_line <= '0;
      fetch_col <= '0;
    end else begin
      el <= el + TW'(CLK_NS);
      fetch_en <= 1'b0;
      case (st)
        S_BOOT: begin
          shift_clk <= 1'b1;
          line_latch <= 1'b1;
          el <= '0;
          st <= S_HI;
        end
        S_HI: if (el_1 > HALF) begin
          shift_clk <= 1'b0;
          st <= S_LO;
        end
        S_LO: if (el_3 > FULL) begin
          fetch_en <= vis;
          fetch_line <= line;
          fetch_col <= col;
          st <= S_REQ;
        end
        S_REQ: begin
          line_latch <= 1'b0;
          st <= S_WAIT;
        end
        S_WAIT: begin
          shift_clk <= 1'b1;
          el <= '0;
          st <= S_HI;
          upper_px <= vis ? fetch_word[7:4] : 4'h0;
          lower_px <= vis ? fetch_word[3:0] : 4'h0;
          line_latch <= last_col;
          if (col == '0) frame_start <= (line == '0);
          if (last_col) begin
            col <= '0;
            line <= last_line ? '0 : line + LW'(1);
          end else begin
            col <= col + CW'(1);
          end
        end
        default: st <= S_BOOT;
      endcase
    end
  end

  logic       sck_d, armed;
  logic [7:0] gap;
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      armed <= 1'b0;
      gap <= '0;
    end else begin
      sck_d <= shift_clk;
      if (shift_clk && !sck_d) begin
        gap <= 8'd1;
        armed <= 1'b1;
      end else if (gap != 8'hff) begin
        gap <= gap + 8'd1;
      end
    end
  end

  AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (rst)
    (shift_clk && !sck_d && armed) |-> (int'(gap) * CLK_NS > SCK_MIN_NS)); // R3
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
    (shift_clk && $past(shift_clk)) |-> $stable({upper_px, lower_px})); // R4
  AST_LATCH_LOW_BEFORE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_clk) |-> !$past(line_latch)); // R6
  AST_FRAME_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(frame_start) || $fell(frame_start)) |-> $rose(shift_clk)); // R7
  AST_NO_DUMMY_FETCH: assert property (@(posedge clk) disable iff (rst)
    fetch_en |-> (fetch_line < LW'(SHOWN))); // R8
  AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> !fetch_en); // R5
endmodule

// File: tb/mono_lcd_scan_bench.sv
module mono_lcd_scan_bench;
  localparam int CLK_NS = 20, MIN_NS = 166, COLS = 8, LINES = 6, SHOWN = 4;
  localparam int CW = $clog2(COLS), LW = $clog2(LINES);

  logic clk = 1'b0, rst = 1'b1;
  logic shift_clk, line_latch, frame_start, fetch_en;
  logic [3:0] upper_px, lower_px;
  logic [LW-1:0] fetch_line;
  logic [CW-1:0] fetch_col;
  logic [7:0] fetch_word = 8'h00;
  logic [7:0] mem [0:LINES*COLS-1];

  always #10 clk = ~clk;

  mono_lcd_scan #(.CLK_NS(CLK_NS), .SCK_MIN_NS(MIN_NS), .COLS(COLS), .LINES(LINES), .SHOWN(SHOWN))
  u_mono_lcd_scan (.clk(clk), .rst(rst), .shift_clk(shift_clk), .line_latch(line_latch),
    .frame_start(frame_start), .upper_px(upper_px), .lower_px(lower_px), .fetch_en(fetch_en),
    .fetch_line(fetch_line), .fetch_col(fetch_col), .fetch_word(fetch_word));

  always @(posedge clk)
    if (fetch_en) fetch_word <= mem[int'(fetch_line) * COLS + int'(fetch_col)];

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hi_len();
    int n = 1;
    while (n * CLK_NS <= MIN_NS / 2) n++;
    return n;
  endfunction

  function automatic int per_len();
    int n = 1;
    while (n * CLK_NS <= MIN_NS) n++;
    if (n < hi_len() + 3) n = hi_len() + 3;
    return n;
  endfunction

  int k = 0, since_rise = 0, hi = 0, reads = 0, rst_age = 0, idle = 0;
  bit booted = 0, prev_sck = 0, prev_lp = 0;
  logic [7:0] prev_px = 8'h00;

  always @(negedge clk) begin
    if (rst) begin
      rst_age++;
      if (rst_age >= 2)
        chk({shift_clk, line_latch, frame_start, upper_px, lower_px, fetch_en} == '0, "R1 reset outputs",
            int'({shift_clk, line_latch, frame_start, upper_px, lower_px, fetch_en}), 0);
      booted = 0; k = 0; since_rise = 0; reads = 0; hi = 0;
      prev_sck = 0; prev_lp = 0; prev_px = 8'h00; idle = 0;
    end else begin
      int el, ec;
      bit rise;
      logic [7:0] ew;
      rst_age = 0;
      since_rise++;
      idle++;
      el = (k / COLS) % LINES;
      ec = k % COLS;
      if (fetch_en) begin
        reads++;
        chk(int'(fetch_line) == el && int'(fetch_col) == ec, "R5 fetch address",
            int'(fetch_line) * 100 + int'(fetch_col), el * 100 + ec);
      end
      rise = shift_clk && !prev_sck;
      if (rise) begin
        idle = 0;
        chk(prev_lp == 0, "R6 latch low before rise", prev_lp, 0);
        if (!booted) begin
          chk(line_latch && {upper_px, lower_px} == 8'h00 && !frame_start, "R2 startup shift",
              int'({line_latch, frame_start, upper_px, lower_px}), 256 * 2);
          chk(reads == 0, "R2 no fetch before startup", reads, 0);
          booted = 1;
        end else begin
          ew = (el < SHOWN) ? mem[el * COLS + ec] : 8'h00;
          chk(since_rise == per_len(), "R3 period", since_rise, per_len());
          chk(upper_px == ew[7:4], "R5 upper nibble", int'(upper_px), int'(ew[7:4]));
          chk(lower_px == ew[3:0], "R5 lower nibble", int'(lower_px), int'(ew[3:0]));
          chk(line_latch == (ec == COLS - 1), "R6 latch level", line_latch, ec == COLS - 1);
          chk(frame_start == (el == 0), "R7 frame marker", frame_start, el == 0);
          chk(reads == ((el < SHOWN) ? 1 : 0), "R8 fetch count", reads, (el < SHOWN) ? 1 : 0);
          if (el == 0 && ec == 0 && k > 0)
            chk(frame_start == 1'b1, "R9 frame wrap", frame_start, 1);
          k++;
        end
        since_rise = 0; reads = 0; hi = 1;
      end else if (shift_clk) begin
        hi++;
        chk({upper_px, lower_px} == prev_px, "R4 bus held", int'({upper_px, lower_px}), int'(prev_px));
      end else if (prev_sck) begin
        chk(hi == hi_len(), "R3 high phase", hi, hi_len());
      end
      if (idle > 200) begin
        chk(0, "watchdog", idle, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
      prev_sck = shift_clk; prev_lp = line_latch; prev_px = {upper_px, lower_px};
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < LINES * COLS; i++) mem[i] = 8'($urandom);
    mem[0] = 8'hff;
    mem[COLS - 1] = 8'h0f;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #5 rst = 1'b0;
    wait (k >= LINES * COLS * 3);
    for (int r = 0; r < 3; r++) begin
      repeat ($urandom_range(50, 400)) @(posedge clk);
      #5 rst = 1'b1;
      repeat (3 + $urandom_range(0, 2)) @(posedge clk);
      #5 rst = 1'b0;
    end
    wait (k >= LINES * COLS * 2 + 1);
    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog timeout", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule